// File: doc/BRIEF.md
# Snoop filter presence tracker

This block is a directory-style snoop filter for a coherent home node. For each cache line it tracks, it records which requesters may hold a copy. For every coherent command it answers with the set of requesters that must be snooped, so the home node sends snoops only to those requesters and not to all of them. Commands carry a line address, a requester number and an operation. The operation is one of the following:

- a lookup;
- an allocate, which adds the requester;
- an update, which makes the requester the only holder;
- a deallocate, which removes the requester.

Tracked lines are held in a set-associative array. A line displaced from that array is not dropped at once. It moves into a small victim queue, and it can still be found and changed there. Only when a line falls out of the victim queue does the filter raise an eviction notice. The notice carries the line address and the requesters that hold it, so the home node can invalidate them.

Each presence vector carries one even-parity bit. When a stored vector fails its parity check, the filter answers as if every requester holds the line, so a broadcast snoop still recovers the data. A build-time coarse mode lets one presence bit stand for a group of requesters, which shrinks the stored vectors.

Top module: `snoop_filter`

## Requirements
- R1: After reset no response and no eviction notice is raised, and a lookup of any line misses with an empty target vector.
- R2: Each accepted command produces exactly one response, with rsp_valid high in the cycle after the command. A hit returns the requesters recorded for the line, with bit i meaning requester i in fine mode. A miss returns hit low, perr low and all-zero targets.
- R3: Allocate adds the requester to the line's presence and creates an entry on a miss. Its response reports the presence held before the command.
- R4: Update replaces the line's presence with the single requester. On a miss it creates the entry.
- R5: Deallocate removes the requester from the line. When that clears the last presence bit the entry is freed, and a later lookup misses. A lookup never changes presence.
- R6: A command issued in the cycle right after another command to the same line sees the result of the earlier command.
- R7: Each stored vector carries even parity. When err_inject is high on a writing command, the stored parity bit is inverted. A parity failure on read sets rsp_perr and returns all ones as targets. A writing command on a failed entry starts from all requesters present and stores correct parity.
- R8: The set index is the low log2(SETS) bits of the line address. Any command that hits the main array refreshes recency. When a set is full, a new line displaces that set's least recently used way.
- R9: A displaced line enters the victim queue. Commands to it still hit and act on it in place.
- R10: When the victim queue is full, a new displacement ejects the oldest victim. In the same cycle as the response, evict_valid is high with that line's address and targets (all ones if its parity failed). The ejected targets are never empty.
- R11: With COARSE=1, presence bit g stands for requesters g*GROUP to g*GROUP+GROUP-1. A set bit reports the whole group as targets, and deallocate leaves presence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 lookup, 1 allocate, 2 update, 3 deallocate |
| cmd_addr | input | ADDR_W | Line address |
| cmd_req | input | log2(NREQ) | Requester number |
| err_inject | input | 1 | Inverts the parity bit written by this command |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Line was tracked |
| rsp_perr | output | 1 | Stored vector failed its parity check |
| rsp_targets | output | NREQ | Requesters to snoop |
| evict_valid | output | 1 | Eviction notice valid |
| evict_addr | output | ADDR_W | Address of the ejected line |
| evict_targets | output | NREQ | Requesters holding the ejected line |

## Verification
A wrong presence bit, age rank or victim slot stays hidden until a command touches the affected line. It then shows in the next cycle as wrong targets or a wrong hit flag, or it shows later as a wrong or missing eviction notice. The bench keeps a behavioural model built from recency-ordered queues and compares every output on every clock. It runs directed sequences that fill sets and the victim queue, and then long random traffic over a small pool of addresses. Together these reach replacement and ejection quickly, so a corrupt internal state comes out within a few commands.

// File: rtl/sf_pkg.sv
package sf_pkg;
    typedef enum logic [1:0] {
        OP_LOOKUP  = 2'd0,
        OP_ALLOC   = 2'd1,
        OP_UPDATE  = 2'd2,
        OP_DEALLOC = 2'd3
    } sf_op_e;
endpackage

// File: rtl/sf_presence_map.sv
// Expands a stored presence vector into per-requester snoop targets.
module sf_presence_map #(
    parameter int NREQ   = 8,
    parameter int COARSE = 0,
    parameter int GROUP  = 2,
    localparam int PW    = (COARSE != 0) ? NREQ / GROUP : NREQ
) (
    input  logic [PW-1:0]   pv_in,
    output logic [NREQ-1:0] targets
);
    generate
        if (COARSE != 0) begin : g_coarse
            for (genvar r = 0; r < NREQ; r++) begin : g_req
                assign targets[r] = pv_in[r / GROUP];
            end
        end else begin : g_fine
            assign targets = pv_in;
        end
    endgenerate
endmodule

// File: rtl/sf_way_pick.sv
// Finds the hit way of a set and the way to fill on a miss.
module sf_way_pick #(
    parameter int WAYS  = 2,
    parameter int AGE_W = 1
) (
    input  logic [WAYS-1:0]            vld,
    input  logic [WAYS-1:0]            match,
    input  logic [WAYS-1:0][AGE_W-1:0] age,
    output logic                       hit,
    output logic [AGE_W-1:0]           hit_way,
    output logic [AGE_W-1:0]           fill_way
);
    always_comb begin
        hit      = 1'b0;
        hit_way  = '0;
        fill_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (vld[w] && match[w]) begin
                hit     = 1'b1;
                hit_way = AGE_W'(w);
            end
            if (age[w] == AGE_W'(WAYS - 1)) fill_way = AGE_W'(w);
        end
        // the lowest free way wins over the oldest way
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld[w]) fill_way = AGE_W'(w);
        end
    end
endmodule

// File: rtl/snoop_filter.sv
module snoop_filter
    import sf_pkg::*;
#(
    parameter int NREQ   = 8,
    parameter int ADDR_W = 12,
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    parameter int VDEPTH = 2,
    parameter int COARSE = 0,
    parameter int GROUP  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [1:0]               cmd_op,
    input  logic [ADDR_W-1:0]        cmd_addr,
    input  logic [$clog2(NREQ)-1:0]  cmd_req,
    input  logic                     err_inject,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic                     rsp_perr,
    output logic [NREQ-1:0]          rsp_targets,
    output logic                     evict_valid,
    output logic [ADDR_W-1:0]        evict_addr,
    output logic [NREQ-1:0]          evict_targets
);
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - SET_W;
    localparam int PW    = (COARSE != 0) ? NREQ / GROUP : NREQ;
    localparam int GSH   = (COARSE != 0) ? $clog2(GROUP) : 0;
    localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int VI_W  = (VDEPTH > 1) ? $clog2(VDEPTH) : 1;

    typedef struct packed {
        logic             v;
        logic [TAG_W-1:0] tag;
        logic [PW-1:0]    pv;
        logic             par;
    } ent_t;

    typedef struct packed {
        logic              v;
        logic [ADDR_W-1:0] addr;
        logic [PW-1:0]     pv;
        logic              par;
    } vent_t;

    typedef struct packed {
        ent_t [SETS-1:0][WAYS-1:0]            arr;
        logic [SETS-1:0][WAYS-1:0][AGE_W-1:0] age;
        vent_t [VDEPTH-1:0]                   vb;
        logic                                 rsp_valid;
        logic                                 rsp_hit;
        logic                                 rsp_perr;
        logic [NREQ-1:0]                      rsp_tg;
        logic                                 ev_valid;
        logic [ADDR_W-1:0]                    ev_addr;
        logic [PW-1:0]                        ev_pv;
        logic                                 ev_perr;
    } state_t;

    state_t st_d, st_q;

    // age ranks: 0 is most recent; touching a way ages the younger ones
    function automatic logic [WAYS-1:0][AGE_W-1:0] touch(
        input logic [WAYS-1:0][AGE_W-1:0] a,
        input logic [AGE_W-1:0]           tw
    );
        logic [WAYS-1:0][AGE_W-1:0] r;
        for (int w = 0; w < WAYS; w++) begin
            if (AGE_W'(w) == tw)   r[w] = '0;
            else if (a[w] < a[tw]) r[w] = a[w] + 1'b1;
            else                   r[w] = a[w];
        end
        return r;
    endfunction

    sf_op_e                     op;
    logic [SET_W-1:0]           set_idx;
    logic [TAG_W-1:0]           tag;
    logic [WAYS-1:0]            row_vld, row_match;
    logic                       mhit, vhit, hit_any, perr;
    logic [AGE_W-1:0]           hit_way, fill_way;
    logic [VI_W-1:0]            vidx;
    logic [PW-1:0]              hit_pv, base_pv, cmd_bit, new_pv;
    logic                       hit_par, wpar;
    logic [NREQ-1:0]            cur_tg, ev_tg;
    vent_t                      disp;
    logic                       placed;

    assign op      = sf_op_e'(cmd_op);
    assign set_idx = cmd_addr[SET_W-1:0];
    assign tag     = cmd_addr[ADDR_W-1:SET_W];

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            row_vld[w]   = st_q.arr[set_idx][w].v;
            row_match[w] = (st_q.arr[set_idx][w].tag == tag);
        end
    end

    sf_way_pick #(.WAYS(WAYS), .AGE_W(AGE_W)) u_way_pick (
        .vld      (row_vld),
        .match    (row_match),
        .age      (st_q.age[set_idx]),
        .hit      (mhit),
        .hit_way  (hit_way),
        .fill_way (fill_way)
    );

    always_comb begin
        vhit = 1'b0;
        vidx = '0;
        for (int j = 0; j < VDEPTH; j++) begin
            if (st_q.vb[j].v && st_q.vb[j].addr == cmd_addr) begin
                vhit = 1'b1;
                vidx = VI_W'(j);
            end
        end
    end

    always_comb begin
        hit_any = mhit | vhit;
        hit_pv  = mhit ? st_q.arr[set_idx][hit_way].pv  : st_q.vb[vidx].pv;
        hit_par = mhit ? st_q.arr[set_idx][hit_way].par : st_q.vb[vidx].par;
        perr    = hit_any & (^{hit_pv, hit_par});
        base_pv = !hit_any ? '0 : (perr ? '1 : hit_pv);
        cmd_bit = PW'(1) << (cmd_req >> GSH);
        case (op)
            OP_ALLOC:   new_pv = base_pv | cmd_bit;
            OP_UPDATE:  new_pv = cmd_bit;
            OP_DEALLOC: new_pv = (COARSE != 0) ? base_pv : (base_pv & ~cmd_bit);
            default:    new_pv = base_pv;
        endcase
        wpar = (^new_pv) ^ err_inject;
    end

    sf_presence_map #(.NREQ(NREQ), .COARSE(COARSE), .GROUP(GROUP)) u_rsp_map (
        .pv_in   (base_pv),
        .targets (cur_tg)
    );

    sf_presence_map #(.NREQ(NREQ), .COARSE(COARSE), .GROUP(GROUP)) u_ev_map (
        .pv_in   (st_q.ev_pv),
        .targets (ev_tg)
    );

    always_comb begin
        st_d          = st_q;
        placed        = 1'b0;
        disp          = '0;
        st_d.rsp_valid = cmd_valid;
        st_d.rsp_hit   = hit_any;
        st_d.rsp_perr  = perr;
        st_d.rsp_tg    = perr ? '1 : cur_tg;
        st_d.ev_valid  = 1'b0;
        if (cmd_valid) begin
            case (op)
                OP_LOOKUP: begin
                    if (mhit) st_d.age[set_idx] = touch(st_q.age[set_idx], hit_way);
                end
                OP_ALLOC, OP_UPDATE: begin
                    if (mhit) begin
                        st_d.arr[set_idx][hit_way].pv  = new_pv;
                        st_d.arr[set_idx][hit_way].par = wpar;
                        st_d.age[set_idx] = touch(st_q.age[set_idx], hit_way);
                    end else if (vhit) begin
                        st_d.vb[vidx].pv  = new_pv;
                        st_d.vb[vidx].par = wpar;
                    end else begin
                        if (st_q.arr[set_idx][fill_way].v) begin
                            disp.v    = 1'b1;
                            disp.addr = {st_q.arr[set_idx][fill_way].tag, set_idx};
                            disp.pv   = st_q.arr[set_idx][fill_way].pv;
                            disp.par  = st_q.arr[set_idx][fill_way].par;
                            if (st_q.vb[VDEPTH-1].v) begin
                                st_d.ev_valid = 1'b1;
                                st_d.ev_addr  = st_q.vb[0].addr;
                                st_d.ev_pv    = st_q.vb[0].pv;
                                st_d.ev_perr  = ^{st_q.vb[0].pv, st_q.vb[0].par};
                                for (int j = 0; j < VDEPTH - 1; j++) st_d.vb[j] = st_q.vb[j+1];
                                st_d.vb[VDEPTH-1] = disp;
                            end else begin
                                for (int j = 0; j < VDEPTH; j++) begin
                                    if (!placed && !st_q.vb[j].v) begin
                                        st_d.vb[j] = disp;
                                        placed     = 1'b1;
                                    end
                                end
                            end
                        end
                        st_d.arr[set_idx][fill_way].v   = 1'b1;
                        st_d.arr[set_idx][fill_way].tag = tag;
                        st_d.arr[set_idx][fill_way].pv  = new_pv;
                        st_d.arr[set_idx][fill_way].par = wpar;
                        st_d.age[set_idx] = touch(st_q.age[set_idx], fill_way);
                    end
                end
                OP_DEALLOC: begin
                    if (mhit) begin
                        if (new_pv == '0) begin
                            st_d.arr[set_idx][hit_way].v = 1'b0;
                        end else begin
                            st_d.arr[set_idx][hit_way].pv  = new_pv;
                            st_d.arr[set_idx][hit_way].par = wpar;
                            st_d.age[set_idx] = touch(st_q.age[set_idx], hit_way);
                        end
                    end else if (vhit) begin
                        if (new_pv == '0) begin
                            for (int j = 0; j < VDEPTH - 1; j++) begin
                                if (VI_W'(j) >= vidx) st_d.vb[j] = st_q.vb[j+1];
                            end
                            st_d.vb[VDEPTH-1] = '0;
                        end else begin
                            st_d.vb[vidx].pv  = new_pv;
                            st_d.vb[vidx].par = wpar;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    st_q.age[s][w] <= AGE_W'(w);
                end
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid     = st_q.rsp_valid;
    assign rsp_hit       = st_q.rsp_hit;
    assign rsp_perr      = st_q.rsp_perr;
    assign rsp_targets   = st_q.rsp_tg;
    assign evict_valid   = st_q.ev_valid;
    assign evict_addr    = st_q.ev_addr;
    assign evict_targets = st_q.ev_perr ? '1 : ev_tg;
endmodule

// File: rtl/sf_check.sv
module sf_check
    import sf_pkg::*;
#(
    parameter int NREQ   = 8,
    parameter int ADDR_W = 12,
    parameter int COARSE = 0,
    parameter int GROUP  = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cmd_valid,
    input logic [1:0]              cmd_op,
    input logic [ADDR_W-1:0]       cmd_addr,
    input logic [$clog2(NREQ)-1:0] cmd_req,
    input logic                    rsp_valid,
    input logic                    rsp_hit,
    input logic                    rsp_perr,
    input logic [NREQ-1:0]         rsp_targets,
    input logic                    evict_valid,
    input logic [NREQ-1:0]         evict_targets
);
    logic [1:0] live_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                live_cnt <= '0;
        else if (live_cnt != 2'd2) live_cnt <= live_cnt + 2'd1;
    end

    // R2
    rsp_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);
    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);
    // R2
    miss_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_targets == '0 && !rsp_perr));
    // R7
    perr_broadcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_perr) |-> (&rsp_targets));
    // R10
    evict_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> (rsp_valid && evict_targets != '0));
    // R6
    b2b_alloc_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt == 2'd2 && $past(cmd_valid) && $past(cmd_op) == OP_LOOKUP
         && $past(cmd_valid, 2) && $past(cmd_op, 2) == OP_ALLOC
         && $past(cmd_addr, 2) == $past(cmd_addr))
        |-> (rsp_hit && rsp_targets[$past(cmd_req, 2)]));

    generate
        if (COARSE != 0) begin : g_grp
            for (genvar g = 0; g < NREQ / GROUP; g++) begin : g_each
                // R11
                group_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    rsp_valid |-> (rsp_targets[g*GROUP +: GROUP] == '0
                                   || (&rsp_targets[g*GROUP +: GROUP])));
            end
        end
    endgenerate
endmodule

bind snoop_filter sf_check #(
    .NREQ(NREQ), .ADDR_W(ADDR_W), .COARSE(COARSE), .GROUP(GROUP)
) u_sf_check (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_req(cmd_req), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_perr(rsp_perr), .rsp_targets(rsp_targets),
    .evict_valid(evict_valid), .evict_targets(evict_targets)
);

// File: tb/snoop_filter_bench.sv
module snoop_filter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NREQ   = 8;
    localparam int ADDR_W = 12;
    localparam int SETS   = 4;
    localparam int WAYS   = 2;
    localparam int VDEPTH = 2;
    localparam int GROUP  = 2;
    localparam int WDOG   = 150000;
    localparam logic [1:0] LK = 2'd0, AL = 2'd1, UP = 2'd2, DE = 2'd3;

    logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, err_inject = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [2:0] cmd_req = '0;

    logic f_rv, f_rh, f_rp, f_ev, c_rv, c_rh, c_rp, c_ev;
    logic [NREQ-1:0] f_rt, f_et, c_rt, c_et;
    logic [ADDR_W-1:0] f_ea, c_ea;

    always #(CLK_PERIOD/2) clk = ~clk;

    snoop_filter #(.NREQ(NREQ), .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS),
                   .VDEPTH(VDEPTH), .COARSE(0), .GROUP(GROUP)) u_snoop_filter (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_req(cmd_req), .err_inject(err_inject),
        .rsp_valid(f_rv), .rsp_hit(f_rh), .rsp_perr(f_rp), .rsp_targets(f_rt),
        .evict_valid(f_ev), .evict_addr(f_ea), .evict_targets(f_et));

    snoop_filter #(.NREQ(NREQ), .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS),
                   .VDEPTH(VDEPTH), .COARSE(1), .GROUP(GROUP)) u_snoop_filter_coarse (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_req(cmd_req), .err_inject(err_inject),
        .rsp_valid(c_rv), .rsp_hit(c_rh), .rsp_perr(c_rp), .rsp_targets(c_rt),
        .evict_valid(c_ev), .evict_addr(c_ea), .evict_targets(c_et));

    typedef struct {
        int              addr;
        logic [NREQ-1:0] pv;
        bit              par;
    } ment_t;

    ment_t ms[2*SETS][$];
    ment_t mv[2][$];

    bit              e_rv[2], e_rh[2], e_rp[2], e_ev[2];
    logic [NREQ-1:0] e_rt[2], e_et[2];
    int              e_ea[2];
    int checks = 0, errors = 0;
    string cur_tag = "R1";

    function automatic logic [NREQ-1:0] mmask(int m);
        return (m == 0) ? {NREQ{1'b1}} : NREQ'((1 << (NREQ / GROUP)) - 1);
    endfunction

    function automatic logic [NREQ-1:0] mexp(int m, logic [NREQ-1:0] pv);
        logic [NREQ-1:0] t;
        if (m == 0) return pv;
        for (int r = 0; r < NREQ; r++) t[r] = pv[r / GROUP];
        return t;
    endfunction

    task automatic model_step(int m, logic [1:0] op, int addr, int req, bit inj);
        int k, mi, vi;
        bit hit, perr, wpar;
        ment_t e, d, o;
        logic [NREQ-1:0] pv, base, bitv, np;
        k = m * SETS + (addr % SETS);
        mi = -1; vi = -1; pv = '0; hit = 0; e.par = 0;
        foreach (ms[k][i]) if (ms[k][i].addr == addr) mi = i;
        foreach (mv[m][i]) if (mv[m][i].addr == addr) vi = i;
        if (mi >= 0) begin hit = 1; pv = ms[k][mi].pv; e.par = ms[k][mi].par; end
        else if (vi >= 0) begin hit = 1; pv = mv[m][vi].pv; e.par = mv[m][vi].par; end
        perr = hit && ((^pv) ^ e.par);
        base = !hit ? '0 : (perr ? mmask(m) : pv);
        e_rv[m] = 1; e_rh[m] = hit; e_rp[m] = perr;
        e_rt[m] = perr ? '1 : mexp(m, base);
        e_ev[m] = 0;
        bitv = NREQ'(1) << ((m == 0) ? req : req / GROUP);
        case (op)
            AL: np = base | bitv;
            UP: np = bitv;
            DE: np = (m == 0) ? (base & ~bitv) : base;
            default: np = base;
        endcase
        wpar = (^np) ^ inj;
        if (op == LK) begin
            if (mi >= 0) begin e = ms[k][mi]; ms[k].delete(mi); ms[k].push_front(e); end
        end else if (op == AL || op == UP) begin
            if (mi >= 0) begin
                e = ms[k][mi]; ms[k].delete(mi); e.pv = np; e.par = wpar; ms[k].push_front(e);
            end else if (vi >= 0) begin
                mv[m][vi].pv = np; mv[m][vi].par = wpar;
            end else begin
                if (ms[k].size() == WAYS) begin
                    d = ms[k].pop_back();
                    if (mv[m].size() == VDEPTH) begin
                        o = mv[m].pop_front();
                        e_ev[m] = 1; e_ea[m] = o.addr;
                        e_et[m] = ((^o.pv) ^ o.par) ? '1 : mexp(m, o.pv);
                    end
                    mv[m].push_back(d);
                end
                e.addr = addr; e.pv = np; e.par = wpar;
                ms[k].push_front(e);
            end
        end else begin
            if (mi >= 0) begin
                e = ms[k][mi]; ms[k].delete(mi);
                if (np != '0) begin e.pv = np; e.par = wpar; ms[k].push_front(e); end
            end else if (vi >= 0) begin
                if (np == '0) mv[m].delete(vi);
                else begin mv[m][vi].pv = np; mv[m][vi].par = wpar; end
            end
        end
    endtask

    task automatic chk(int m, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s dut%0d %s act=%0h exp=%0h", cur_tag, m, what, act, exp);
        end
    endtask

    task automatic compare_all();
        for (int m = 0; m < 2; m++) begin
            chk(m, "rsp_valid", 32'(m == 0 ? f_rv : c_rv), 32'(e_rv[m]));
            chk(m, "evict_valid", 32'(m == 0 ? f_ev : c_ev), 32'(e_ev[m]));
            if (e_rv[m]) begin
                chk(m, "rsp_hit", 32'(m == 0 ? f_rh : c_rh), 32'(e_rh[m]));
                chk(m, "rsp_perr", 32'(m == 0 ? f_rp : c_rp), 32'(e_rp[m]));
                chk(m, "rsp_targets", 32'(m == 0 ? f_rt : c_rt), 32'(e_rt[m]));
            end
            if (e_ev[m]) begin
                chk(m, "evict_addr", 32'(m == 0 ? f_ea : c_ea), 32'(e_ea[m]));
                chk(m, "evict_targets", 32'(m == 0 ? f_et : c_et), 32'(e_et[m]));
            end
        end
    endtask

    task automatic cmd(logic [1:0] op, int addr, int req, bit inj);
        @(negedge clk);
        compare_all();
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = ADDR_W'(addr);
        cmd_req = 3'(req); err_inject = inj;
        for (int m = 0; m < 2; m++) model_step(m, op, addr, req, inj);
    endtask

    task automatic idle();
        @(negedge clk);
        compare_all();
        cmd_valid = 1'b0; err_inject = 1'b0;
        for (int m = 0; m < 2; m++) begin e_rv[m] = 0; e_ev[m] = 0; end
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements act=timeout exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int m = 0; m < 2; m++) begin e_rv[m] = 0; e_ev[m] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_tag = "R1";
        idle(); idle();
        cmd(LK, 12'h010, 0, 0); idle();
        cur_tag = "R3";
        cmd(AL, 12'h010, 1, 0);
        cur_tag = "R6";
        cmd(AL, 12'h010, 3, 0);
        cur_tag = "R2";
        cmd(LK, 12'h010, 0, 0); cmd(LK, 12'h014, 0, 0);
        cur_tag = "R4";
        cmd(UP, 12'h010, 5, 0); cmd(LK, 12'h010, 0, 0);
        cur_tag = "R5";
        cmd(LK, 12'h010, 2, 0); cmd(LK, 12'h010, 2, 0);
        cmd(DE, 12'h010, 3, 0); cmd(DE, 12'h010, 5, 0); cmd(LK, 12'h010, 0, 0);
        cur_tag = "R7";
        cmd(AL, 12'h022, 2, 1); cmd(LK, 12'h022, 0, 0);
        cmd(AL, 12'h022, 4, 0); cmd(LK, 12'h022, 0, 0);
        cmd(UP, 12'h022, 0, 1); cmd(DE, 12'h022, 0, 0); cmd(LK, 12'h022, 0, 0);
        cur_tag = "R8";
        cmd(AL, 12'h101, 1, 0); cmd(AL, 12'h105, 2, 0); cmd(LK, 12'h101, 0, 0);
        cmd(AL, 12'h109, 3, 0); cmd(LK, 12'h101, 0, 0);
        cur_tag = "R9";
        cmd(LK, 12'h105, 0, 0); cmd(AL, 12'h105, 6, 0); cmd(LK, 12'h105, 0, 0);
        cur_tag = "R10";
        cmd(AL, 12'h10D, 4, 0); cmd(AL, 12'h111, 5, 0); cmd(AL, 12'h115, 7, 0);
        cmd(AL, 12'h203, 1, 1); cmd(AL, 12'h207, 2, 0); cmd(AL, 12'h20B, 3, 0);
        cmd(AL, 12'h119, 4, 0); cmd(AL, 12'h11D, 5, 0); cmd(AL, 12'h121, 6, 0);
        cmd(AL, 12'h20F, 0, 0); idle();
        cur_tag = "R11";
        cmd(AL, 12'h030, 3, 0); cmd(LK, 12'h030, 0, 0);
        cmd(DE, 12'h030, 3, 0); cmd(LK, 12'h030, 0, 0);
        cmd(AL, 12'h030, 6, 0); cmd(LK, 12'h030, 0, 0); idle();
        cur_tag = "R6";
        for (int i = 0; i < 3000; i++) begin
            int sel;
            sel = $urandom_range(0, 9);
            if (sel == 0) idle();
            else cmd(2'($urandom_range(0, 3)), 12'h300 + $urandom_range(0, 23),
                     $urandom_range(0, NREQ - 1), ($urandom_range(0, 19) == 0));
        end
        idle(); idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule